// File: doc/BRIEF.md
# Radio Packet Transmit Framer

This block turns a short packet held in a local byte buffer into the serial chip stream for a narrow-band radio modem. When a start pulse arrives, it reads the first byte of the buffer, called the control byte. The low five bits of that byte give the packet length. A length that is out of range is refused with an error pulse. Otherwise the block raises the transmitter enable and waits one bit time. It then sends an alternating preamble, a fixed frame sync byte, every buffered byte unchanged, and finally a one-byte check value.

Every data bit leaves the block Manchester coded as two chips of equal length, so the line carries as many marks as spaces. A strobe marks the first clock of each chip. The preamble can be the normal length (a parameter, about 5 ms at the nominal 64 kbit/s rate) or an extended length taken from an input. The extended length lets the frame reach receivers that wake only now and then. A done pulse closes the frame at the same edge where the transmitter enable drops.

Top module: `rpf_framer`

## Requirements
- R1: While reset is high and at the first edge after it, tx_en, tx_bit, bit_stb, done and err are all 0 and rd_addr is 0.
- R2: At start, bits 4:0 of buffer byte 0 hold the total byte count, control byte included. A count of 0 or above 27 gives a single-cycle err on the next clock, and tx_en stays 0. Bits 7:5 play no part in framing.
- R3: For a valid count, tx_en is 1 from the clock after start. The first bit_stb comes exactly 2*CHIP_DIV clocks after tx_en rises.
- R4: The preamble is a run of alternating data bits starting with 1. It has NORM_PRE_BITS bits when ext_pre is 0 or ext_pre_len is 0, and ext_pre_len bits otherwise.
- R5: After the preamble, the sync byte 0xA7 is sent most significant bit first.
- R6: Next, buffer bytes at addresses 0 up to count-1 are sent unchanged, in address order, each most significant bit first.
- R7: The last byte sent is the check value C, chosen so that the 8-bit sum of all buffer bytes sent plus C is 0.
- R8: A data bit of 1 is sent as chip 1 then chip 0, and a 0 as chip 0 then chip 1. Each chip lasts CHIP_DIV clocks, and bit_stb is high only in the first clock of each chip.
- R9: done is a single-cycle pulse on the clock where tx_en falls. This comes right after the last chip of the check byte, and the chip count is exactly 2*(preamble + 8 + 8*count + 8).
- R10: A start pulse while tx_en is 1 has no effect: the frame in progress runs unchanged and nothing is sent after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to send the buffered packet |
| ext_pre | input | 1 | Selects the extended preamble |
| ext_pre_len | input | PRE_W | Extended preamble length in bits |
| rd_addr | output | ADDR_W | Buffer read address |
| rd_data | input | 8 | Buffer byte at rd_addr, combinational read |
| tx_bit | output | 1 | Current line chip |
| bit_stb | output | 1 | High in the first clock of each chip |
| tx_en | output | 1 | Transmitter enable |
| done | output | 1 | Frame finished pulse |
| err | output | 1 | Bad length pulse |

## Verification
The assertions assume that the buffer is a combinational read port and that its contents stay fixed from start until done. They also assume that start is a clean single-cycle pulse. The bench meets these assumptions by filling the buffer model before each start pulse and leaving it untouched until the frame ends. It drives every input on the falling edge. The extended length is changed only while the block is idle, which is the only time the block samples it.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
    localparam int          MAX_BYTES = 27;
    localparam logic [7:0]  SYNC_WORD = 8'hA7;

    typedef enum logic [2:0] {
        PH_IDLE, PH_LEAD, PH_PRE, PH_SYNC, PH_DATA, PH_CSUM
    } phase_t;

    function automatic logic [4:0] ctrl_count(input logic [7:0] b);
        return b[4:0];
    endfunction

    function automatic logic count_ok(input logic [4:0] c);
        return (c != 5'd0) && (c <= 5'(MAX_BYTES));
    endfunction

    function automatic logic manch_chip(input logic data, input logic second);
        return second ? ~data : data;
    endfunction

    function automatic logic on_air(input phase_t p);
        return (p == PH_PRE) || (p == PH_SYNC) || (p == PH_DATA) || (p == PH_CSUM);
    endfunction
endpackage

// File: rtl/rpf_tick.sv
module rpf_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick,
    output logic first
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run)
            cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
    end

    assign tick  = run && (cnt == CW'(DIV - 1));
    assign first = run && (cnt == '0);
endmodule

// File: rtl/rpf_csum.sv
module rpf_csum (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       add,
    input  logic [7:0] byte_in,
    output logic [7:0] check
);
    logic [7:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc <= '0;
        else if (add)
            acc <= acc + byte_in;
    end

    assign check = 8'd0 - acc;
endmodule

// File: rtl/rpf_framer.sv
module rpf_framer
    import rpf_pkg::*;
#(
    parameter int CHIP_DIV      = 8,
    parameter int NORM_PRE_BITS = 320,
    parameter int PRE_W         = 12,
    parameter int ADDR_W        = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ext_pre,
    input  logic [PRE_W-1:0]  ext_pre_len,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              tx_bit,
    output logic              bit_stb,
    output logic              tx_en,
    output logic              done,
    output logic              err
);
    phase_t            phase;
    logic              h;
    logic [7:0]        sr;
    logic [PRE_W-1:0]  bitcnt;
    logic [PRE_W-1:0]  pre_last;
    logic [ADDR_W-1:0] idx;
    logic [4:0]        len;
    logic              done_q, err_q;

    logic       tick, chip_first, run, accept, bit_end, byte_end, add_byte;
    logic [7:0] check;

    assign run      = (phase != PH_IDLE);
    assign accept   = (phase == PH_IDLE) && start && count_ok(ctrl_count(rd_data));
    assign bit_end  = tick && h;
    assign byte_end = bit_end && (bitcnt == PRE_W'(7));
    assign add_byte = byte_end && ((phase == PH_SYNC) ||
                      ((phase == PH_DATA) && (idx != ADDR_W'(len))));

    rpf_tick #(.DIV(CHIP_DIV)) u_tick (
        .clk(clk), .rst(rst), .clr(accept), .run(run),
        .tick(tick), .first(chip_first)
    );

    rpf_csum u_csum (
        .clk(clk), .rst(rst), .clr(accept), .add(add_byte),
        .byte_in(rd_data), .check(check)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            h        <= 1'b0;
            sr       <= '0;
            bitcnt   <= '0;
            pre_last <= '0;
            idx      <= '0;
            len      <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    if (accept) begin
                        phase    <= PH_LEAD;
                        h        <= 1'b0;
                        bitcnt   <= '0;
                        len      <= ctrl_count(rd_data);
                        pre_last <= (ext_pre && ext_pre_len != '0) ?
                                    ext_pre_len - 1'b1 : PRE_W'(NORM_PRE_BITS - 1);
                    end else begin
                        err_q <= 1'b1;
                    end
                end
            end else begin
                if (tick)
                    h <= ~h;
                if (bit_end) begin
                    case (phase)
                        PH_LEAD: begin
                            phase  <= PH_PRE;
                            sr     <= 8'h80;
                            bitcnt <= '0;
                        end
                        PH_PRE: begin
                            if (bitcnt == pre_last) begin
                                phase  <= PH_SYNC;
                                sr     <= SYNC_WORD;
                                bitcnt <= '0;
                            end else begin
                                sr     <= {~sr[7], 7'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                        PH_SYNC, PH_DATA: begin
                            if (bitcnt == PRE_W'(7)) begin
                                bitcnt <= '0;
                                if (phase == PH_DATA && idx == ADDR_W'(len)) begin
                                    phase <= PH_CSUM;
                                    sr    <= check;
                                end else begin
                                    phase <= PH_DATA;
                                    sr    <= rd_data;
                                    idx   <= idx + 1'b1;
                                end
                            end else begin
                                sr     <= {sr[6:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                        PH_CSUM: begin
                            if (bitcnt == PRE_W'(7)) begin
                                phase  <= PH_IDLE;
                                idx    <= '0;
                                done_q <= 1'b1;
                            end else begin
                                sr     <= {sr[6:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                        default: phase <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    assign rd_addr = idx;
    assign tx_en   = run;
    assign bit_stb = on_air(phase) && chip_first;
    assign tx_bit  = on_air(phase) && manch_chip(sr[7], h);
    assign done    = done_q;
    assign err     = err_q;
endmodule

// File: rtl/rpf_framer_chk.sv
module rpf_framer_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              tx_en,
    input logic              tx_bit,
    input logic              bit_stb,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              half
);
    logic first_chip;

    always_ff @(posedge clk) begin
        if (rst)
            first_chip <= 1'b0;
        else if (bit_stb && !half)
            first_chip <= tx_bit;
    end

    p_err_silent_r2: assert property (@(posedge clk) disable iff (rst)
        err |-> !tx_en);

    p_stb_inside_r8: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> tx_en);

    p_chip_pair_r8: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && half) |-> (tx_bit != first_chip));

    p_done_edge_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!tx_en && $past(tx_en)));

    p_no_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_en && start) |=> (tx_en || done));

    p_addr_range_r6: assert property (@(posedge clk) disable iff (rst)
        rd_addr <= ADDR_W'(rpf_pkg::MAX_BYTES));

    p_lead_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> !bit_stb);
endmodule

bind rpf_framer rpf_framer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .tx_en(tx_en), .tx_bit(tx_bit),
    .bit_stb(bit_stb), .done(done), .err(err), .rd_addr(rd_addr), .half(h)
);

// File: tb/rpf_framer_test.sv
module rpf_framer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 2;
    localparam int NPRE = 8;
    localparam int PW   = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          ext_pre = 1'b0;
    logic [PW-1:0] ext_pre_len = '0;
    logic [4:0]    rd_addr;
    logic [7:0]    rd_data;
    logic          tx_bit, bit_stb, tx_en, done, err;

    logic [7:0] mem [0:31];
    assign rd_data = mem[rd_addr];

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    rpf_framer #(.CHIP_DIV(DIV), .NORM_PRE_BITS(NPRE), .PRE_W(PW), .ADDR_W(5)) uut (
        .clk(clk), .rst(rst), .start(start), .ext_pre(ext_pre),
        .ext_pre_len(ext_pre_len), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_bit(tx_bit), .bit_stb(bit_stb), .tx_en(tx_en), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic run_frame(input int len, input bit typ, input bit ext,
                             input int el, input int seed, input bit poke);
        int  exp_bits [0:599];
        int  chips    [0:1199];
        int  nb = 0, pc, sum, ck, nchip, k, first_k, last_k, gap_bad;
        int  stb_out, bad_pre, bad_sync, bad_data, bad_ck, bad_man;
        bit  got_done, done_txen;
        mem[0] = {typ, 2'b00, len[4:0]};
        for (int i = 1; i < len; i++) mem[i] = 8'((seed * 37 + i * 11 + i * i) & 255);
        pc = (ext && el != 0) ? el : NPRE;
        for (int p = 0; p < pc; p++) exp_bits[nb++] = (p % 2 == 0) ? 1 : 0;
        for (int b = 7; b >= 0; b--) exp_bits[nb++] = (8'hA7 >> b) & 1;
        sum = 0;
        for (int i = 0; i < len; i++) begin
            sum += mem[i];
            for (int b = 7; b >= 0; b--) exp_bits[nb++] = (mem[i] >> b) & 1;
        end
        ck = (256 - (sum & 255)) & 255;
        for (int b = 7; b >= 0; b--) exp_bits[nb++] = (ck >> b) & 1;

        ext_pre = ext;
        ext_pre_len = PW'(el);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(tx_en == 1'b1 && err == 1'b0, "R3 tx_en after start", int'(tx_en), 1);
        nchip = 0; k = 0; first_k = -1; last_k = 0; gap_bad = 0; stb_out = 0;
        got_done = 0; done_txen = 0;
        while (!got_done && k < 5000) begin
            @(negedge clk);
            k++;
            start = (poke && k == 40) ? 1'b1 : 1'b0;
            if (bit_stb) begin
                if (!tx_en) stb_out++;
                if (first_k < 0) first_k = k;
                else if (k - last_k != DIV) gap_bad++;
                last_k = k;
                chips[nchip++] = int'(tx_bit);
            end
            if (done) begin
                got_done = 1;
                done_txen = tx_en;
            end
        end
        start = 1'b0;
        chk(first_k == 2 * DIV, "R3 lead before first chip", first_k, 2 * DIV);
        chk(got_done && !done_txen, "R9 done with tx_en low", int'(done_txen), 0);
        chk(nchip == 2 * nb, "R9 chip count", nchip, 2 * nb);
        chk(gap_bad == 0 && stb_out == 0, "R8 chip spacing", gap_bad + stb_out, 0);
        bad_pre = 0; bad_sync = 0; bad_data = 0; bad_ck = 0; bad_man = 0;
        for (int i = 0; i < nb && 2 * i + 1 < nchip; i++) begin
            if (chips[2*i] == chips[2*i+1]) bad_man++;
            if (chips[2*i] != exp_bits[i]) begin
                if (i < pc) bad_pre++;
                else if (i < pc + 8) bad_sync++;
                else if (i < nb - 8) bad_data++;
                else bad_ck++;
            end
        end
        chk(bad_man == 0, "R8 manchester pairs", bad_man, 0);
        chk(bad_pre == 0, "R4 preamble", bad_pre, 0);
        chk(bad_sync == 0, "R5 sync byte", bad_sync, 0);
        chk(bad_data == 0, "R6 payload", bad_data, 0);
        chk(bad_ck == 0, "R7 check byte", bad_ck, 0);
        @(negedge clk);
        chk(done == 1'b0 && tx_en == 1'b0, "R9 single done", int'(done), 0);
        if (poke) begin
            repeat (4 * DIV) @(negedge clk);
            chk(tx_en == 1'b0 && bit_stb == 1'b0, "R10 start while busy ignored",
                int'(tx_en), 0);
        end
    endtask

    task automatic bad_ctrl(input logic [7:0] v);
        mem[0] = v;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(err == 1'b1 && tx_en == 1'b0, "R2 bad count err", int'(err), 1);
        @(negedge clk);
        chk(err == 1'b0 && tx_en == 1'b0, "R2 err single pulse", int'(err), 0);
        repeat (4) @(negedge clk);
        chk(tx_en == 1'b0 && bit_stb == 1'b0, "R2 nothing sent", int'(tx_en), 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(tx_en == 0 && tx_bit == 0 && bit_stb == 0 && done == 0 && err == 0
            && rd_addr == 0, "R1 reset state", int'(tx_en), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_en == 0 && bit_stb == 0 && done == 0 && err == 0,
            "R1 idle after reset", int'(tx_en), 0);
        for (int n = 1; n <= 27; n++) run_frame(n, n[0], 1'b0, 0, n, n == 5);
        run_frame(10, 1'b0, 1'b1, 3, 77, 1'b0);
        run_frame(4, 1'b1, 1'b1, 20, 13, 1'b0);
        run_frame(3, 1'b0, 1'b1, 0, 5, 1'b0);
        run_frame(27, 1'b1, 1'b1, 1, 99, 1'b1);
        run_frame(6, 1'b0, 1'b0, 40, 21, 1'b0);
        bad_ctrl(8'h00);
        bad_ctrl(8'h1C);
        bad_ctrl(8'h1F);
        bad_ctrl(8'h80);
        run_frame(2, 1'b1, 1'b0, 0, 3, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule